// File: doc/BRIEF.md
# Background Program-Memory CRC Checker

This block guards a program memory against silent corruption. While checking is on, it keeps a count of frame ticks. Each time a set number of ticks has passed, it reads the whole memory through a synchronous read port, one 32-bit word per cycle, and folds every word into a 32-bit CRC. When the last word has been folded in, the result is compared with an expected value that a host wrote earlier. Any mismatch raises a sticky error flag. The host can read that flag, and it can also be routed to an output pin, for example to interrupt a controller that then reloads the memory.

The host works through a simple register interface with a write strobe and a read strobe. The expected CRC is written as two 16-bit halves. The host then sets a one-bit run enable, and it can turn on routing of the flag to the pin with a second one-bit control. Clearing the run enable stops all checking and clears the flag. The intended order is: load the memory, write the expected value, then set the enable.

Top module: `crc_mem_checker`

## Requirements
- R1: Register 0 holds bits 31:16 of the expected CRC and register 1 holds bits 15:0. Both reset to 0. A read strobe returns the current contents on `host_rdata` one cycle later.
- R2: Register 2 bit 0 is the run enable and register 3 bit 0 is the pin-route enable. Both reset to 0, read back their current value, and read 0 in bits 15:1.
- R3: While the run enable is 0, the block issues no memory reads and the error flag stays 0, whatever the memory and the expected value hold.
- R4: After the run enable rises, the tick count starts again from zero. A scan begins on every FRAMES_PER_CHECK-th tick. A resulting flag appears within DEPTH+6 cycles of that tick and never before it.
- R5: The CRC uses polynomial 0x04C11DB7 with start value 0xFFFFFFFF and no final inversion. Each word is taken most significant bit first, over addresses 0 to DEPTH-1 in ascending order. A scan whose result equals the expected value leaves the flag at 0.
- R6: Once set, the flag stays at 1 while the run enable stays at 1, even if later scans match.
- R7: Writing the run enable to 0 clears the flag. The flag stays 0 until the enable is 1 again and a new scan mismatches.
- R8: Register 4 is read-only status. Bit 0 is the error flag and bits 15:1 read 0. Writes to it change nothing.
- R9: `crc_err_pin` equals the flag while the pin-route enable is 1, and is held at 0 while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per frame |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register select |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid one cycle after `host_rd` |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | $clog2(DEPTH) | Memory word address |
| mem_rd_data | input | 32 | Memory word, one cycle after the request |
| crc_err_pin | output | 1 | Routed error flag |

## Verification
The assertions assume that frame ticks are spread out enough for one scan to finish before the next interval ends. They also assume the memory answers every request in exactly the following cycle. The bench spaces ticks four cycles apart, uses an interval of eight ticks over an eight-word memory, and models the memory as a one-cycle registered read. It changes memory contents only while the checker is disabled, or between scans when a fault is being injected on purpose. Several memory fill patterns are each run once with a matching expected value and once with a single flipped bit.

// File: rtl/crc_chk_pkg.sv
// Package: shared constants and the CRC step for the memory checker.
// Assumes a 32-bit memory word and a 16-bit host data path.
package crc_chk_pkg;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    localparam int HOST_AW = 3;
    localparam int HOST_DW = 16;

    localparam logic [HOST_AW-1:0] RA_EXP_HI = 3'd0;
    localparam logic [HOST_AW-1:0] RA_EXP_LO = 3'd1;
    localparam logic [HOST_AW-1:0] RA_RUN    = 3'd2;
    localparam logic [HOST_AW-1:0] RA_PIN    = 3'd3;
    localparam logic [HOST_AW-1:0] RA_STAT   = 3'd4;

    // Fold one 32-bit word into the running CRC, most significant bit first.
    function automatic logic [31:0] crc_fold(input logic [31:0] crc_in, input logic [31:0] word);
        logic [31:0] c;
        c = crc_in;
        for (int b = 31; b >= 0; b--) begin
            if (c[31] ^ word[b]) c = {c[30:0], 1'b0} ^ CRC_POLY;
            else                 c = {c[30:0], 1'b0};
        end
        return c;
    endfunction
endpackage

// File: rtl/crc_chk_interval.sv
// Interval timer: counts frame ticks while checking is on and pulses
// scan_go on every FRAMES-th tick. Assumes ticks are single-cycle pulses.
// The count starts again from zero whenever run is low.
module crc_chk_interval #(
    parameter int FRAMES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic scan_go
);
    localparam int CW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

    logic [CW-1:0] cnt;

    // Count ticks and issue a one-cycle scan request at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt     <= '0;
            scan_go <= 1'b0;
        end else begin
            scan_go <= 1'b0;
            if (tick) begin
                if (cnt == LAST) begin
                    cnt     <= '0;
                    scan_go <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_GO_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        scan_go |-> $past(tick) && $past(run)); // R4
endmodule

// File: rtl/crc_chk_engine.sv
// Scan engine: reads DEPTH words with a one-cycle read latency, folds them
// into the CRC and compares with the expected value after the last word.
// Assumes each scan finishes before the next scan_go arrives.
// A low run aborts any scan in progress.
module crc_chk_engine
    import crc_chk_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       scan_go,
    input  logic [31:0]                expected,
    output logic                       rd_en,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    input  logic [31:0]                rd_data,
    output logic                       done,
    output logic                       mismatch
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    logic        busy;
    logic        vld_d;
    logic        last_d;
    logic [31:0] crc;
    logic [31:0] crc_nx;

    // Next CRC value once the returning word is folded in.
    always_comb crc_nx = crc_fold(crc, rd_data);

    // Sequence the reads, fold the returning data, and compare at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            busy     <= 1'b0;
            rd_en    <= 1'b0;
            rd_addr  <= '0;
            vld_d    <= 1'b0;
            last_d   <= 1'b0;
            crc      <= CRC_SEED;
            done     <= 1'b0;
            mismatch <= 1'b0;
        end else begin
            done   <= 1'b0;
            vld_d  <= rd_en;
            last_d <= rd_en && (rd_addr == TOP);
            if (scan_go && !busy) begin
                busy    <= 1'b1;
                rd_en   <= 1'b1;
                rd_addr <= '0;
                crc     <= CRC_SEED;
            end else if (rd_en) begin
                if (rd_addr == TOP) rd_en <= 1'b0;
                else                rd_addr <= rd_addr + 1'b1;
            end
            if (vld_d) begin
                crc <= crc_nx;
                if (last_d) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    mismatch <= (crc_nx != expected);
                end
            end
        end
    end

    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_go |-> !busy); // R4
    AST_NO_READ_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !rd_en && !done); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + 1'b1); // R5
endmodule

// File: rtl/crc_chk_regs.sv
// Host register file: expected CRC halves, run and pin-route controls,
// the sticky error flag and the registered read path.
// Assumes at most one of write or read per cycle matters for a given address.
module crc_chk_regs
    import crc_chk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               rd,
    input  logic [HOST_AW-1:0] addr,
    input  logic [HOST_DW-1:0] wdata,
    output logic [HOST_DW-1:0] rdata,
    input  logic               done,
    input  logic               mismatch,
    output logic [31:0]        expected,
    output logic               run,
    output logic               err_pin
);
    logic       pin_route;
    logic       err_flag;
    logic [HOST_DW-1:0] rd_mux;

    // Accept host writes to the writable controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expected  <= '0;
            run       <= 1'b0;
            pin_route <= 1'b0;
        end else if (wr) begin
            case (addr)
                RA_EXP_HI: expected[31:16] <= wdata;
                RA_EXP_LO: expected[15:0]  <= wdata;
                RA_RUN:    run             <= wdata[0];
                RA_PIN:    pin_route       <= wdata[0];
                default: ;
            endcase
        end
    end

    // Sticky error flag: set on a failed compare, cleared while run is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) err_flag <= 1'b0;
        else if (done && mismatch) err_flag <= 1'b1;
    end

    // Select the register being read.
    always_comb begin
        case (addr)
            RA_EXP_HI: rd_mux = expected[31:16];
            RA_EXP_LO: rd_mux = expected[15:0];
            RA_RUN:    rd_mux = {15'd0, run};
            RA_PIN:    rd_mux = {15'd0, pin_route};
            RA_STAT:   rd_mux = {15'd0, err_flag};
            default:   rd_mux = '0;
        endcase
    end

    // Register the read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    // Drive the pin only when routing is enabled.
    always_comb err_pin = pin_route & err_flag;

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_flag) && run |-> err_flag); // R6
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !err_flag); // R7
    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_route |-> !err_pin); // R9
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(done) && $past(mismatch)); // R5
endmodule

// File: rtl/crc_mem_checker.sv
// Top level: ties the host registers, the interval timer and the scan
// engine together. Assumes the memory returns data one cycle after rd_en.
module crc_mem_checker
    import crc_chk_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int FRAMES = 4096
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_tick,
    input  logic                      host_wr,
    input  logic                      host_rd,
    input  logic [2:0]                host_addr,
    input  logic [15:0]               host_wdata,
    output logic [15:0]               host_rdata,
    output logic                      mem_rd_en,
    output logic [$clog2(DEPTH)-1:0]  mem_addr,
    input  logic [31:0]               mem_rd_data,
    output logic                      crc_err_pin
);
    logic        run;
    logic        scan_go;
    logic        done;
    logic        mismatch;
    logic [31:0] expected;

    crc_chk_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .rd(host_rd),
        .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
        .done(done), .mismatch(mismatch), .expected(expected),
        .run(run), .err_pin(crc_err_pin)
    );

    crc_chk_interval #(.FRAMES(FRAMES)) u_interval (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(frame_tick), .scan_go(scan_go)
    );

    crc_chk_engine #(.DEPTH(DEPTH)) u_engine (
        .clk(clk), .rst_n(rst_n), .run(run), .scan_go(scan_go),
        .expected(expected), .rd_en(mem_rd_en), .rd_addr(mem_addr),
        .rd_data(mem_rd_data), .done(done), .mismatch(mismatch)
    );
endmodule

// File: tb/crc_mem_checker_test.sv
module crc_mem_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int FRAMES = 8;
    localparam int AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_tick = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [2:0]    host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic [15:0]   host_rdata;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rd_data;
    logic          crc_err_pin;

    logic [31:0] mem [DEPTH];
    int compared = 0;
    int mismatched = 0;
    int stray_reads = 0;
    logic count_stray = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_mem_checker #(.DEPTH(DEPTH), .FRAMES(FRAMES)) uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .crc_err_pin(crc_err_pin)
    );

    // Memory model with a one-cycle registered read.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr];

    // Count any read request made while checking is meant to be off.
    always @(negedge clk) if (count_stray && mem_rd_en) stray_reads++;

    function automatic logic [31:0] ref_crc();
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int w = 0; w < DEPTH; w++)
            for (int b = 31; b >= 0; b--) begin
                logic fb = c[31] ^ mem[w][b];
                c = c << 1;
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); host_rd = 1'b1; host_addr = a;
        @(negedge clk); host_rd = 1'b0; d = host_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); frame_tick = 1'b1;
            @(negedge clk); frame_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic set_exp(input logic [31:0] v);
        wr(3'd0, v[31:16]);
        wr(3'd1, v[15:0]);
    endtask

    task automatic fill(input int p);
        for (int i = 0; i < DEPTH; i++)
            mem[i] = (32'h9E37_79B9 * (p + 1)) ^ (32'(i) << (p * 3)) ^ 32'(p * 77 + i);
    endtask

    logic [15:0] r;

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R8 R9: reset values
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), r);
            check($sformatf("R1/R2/R8 reset reg%0d", a), 32'(r), 32'd0);
        end
        check("R9 pin at reset", 32'(crc_err_pin), 0);

        // R1: halves land in the right registers
        set_exp(32'hA5C3_1E0F);
        rd(3'd0, r); check("R1 high half", 32'(r), 32'hA5C3);
        rd(3'd1, r); check("R1 low half", 32'(r), 32'h1E0F);
        // R2: control readback, upper bits zero
        wr(3'd3, 16'hFFFF);
        rd(3'd3, r); check("R2 pin-route readback", 32'(r), 32'd1);
        wr(3'd3, 16'h0000);
        // R8: status write ignored
        wr(3'd4, 16'hFFFF);
        rd(3'd4, r); check("R8 status write ignored", 32'(r), 32'd0);

        // R3: disabled, wrong expected, many intervals: no reads, no flag
        count_stray = 1'b1;
        ticks(3 * FRAMES);
        count_stray = 1'b0;
        check("R3 no reads while disabled", 32'(stray_reads), 32'd0);
        rd(3'd4, r); check("R3 flag stays 0 while disabled", 32'(r), 32'd0);

        // Sweep several fill patterns: match then single-bit fault
        for (int p = 0; p < 4; p++) begin
            fill(p);
            set_exp(ref_crc());
            wr(3'd2, 16'h0001);
            rd(3'd2, r); check("R2 run readback", 32'(r), 32'd1);
            ticks(2 * FRAMES);
            repeat (DEPTH + 6) @(negedge clk);
            rd(3'd4, r); check($sformatf("R5 matching pattern %0d", p), 32'(r), 32'd0);
            // inject fault between scans
            mem[p % DEPTH][(p * 9) % 32] ^= 1'b1;
            ticks(FRAMES - 1);
            repeat (DEPTH + 6) @(negedge clk);
            rd(3'd4, r); check($sformatf("R4 no flag before interval p%0d", p), 32'(r), 32'd0);
            ticks(1);
            repeat (DEPTH + 6) @(negedge clk);
            rd(3'd4, r); check($sformatf("R4/R8 flag after interval p%0d", p), 32'(r), 32'd1);
            // R6: repair memory, later matching scans keep flag
            mem[p % DEPTH][(p * 9) % 32] ^= 1'b1;
            ticks(2 * FRAMES);
            repeat (DEPTH + 6) @(negedge clk);
            rd(3'd4, r); check($sformatf("R6 flag sticky p%0d", p), 32'(r), 32'd1);
            // R9: pin routing
            check("R9 pin low when not routed", 32'(crc_err_pin), 0);
            wr(3'd3, 16'h0001);
            @(negedge clk);
            check("R9 pin follows flag", 32'(crc_err_pin), 1);
            wr(3'd3, 16'h0000);
            // R7: clear by dropping the enable
            wr(3'd2, 16'h0000);
            repeat (2) @(negedge clk);
            rd(3'd4, r); check($sformatf("R7 cleared p%0d", p), 32'(r), 32'd0);
        end

        // R1 ordering: swapped halves are a mismatch
        fill(1);
        set_exp({ref_crc()[15:0], ref_crc()[31:16]});
        wr(3'd2, 16'h0001);
        ticks(FRAMES);
        repeat (DEPTH + 6) @(negedge clk);
        rd(3'd4, r); check("R1 swapped halves mismatch", 32'(r), 32'd1);
        // R7: stays cleared until re-enabled and a new mismatch
        wr(3'd2, 16'h0000);
        ticks(FRAMES);
        rd(3'd4, r); check("R7 stays clear while disabled", 32'(r), 32'd0);
        set_exp(ref_crc());
        wr(3'd2, 16'h0001);
        ticks(2 * FRAMES);
        repeat (DEPTH + 6) @(negedge clk);
        rd(3'd4, r); check("R7 no flag after re-enable with match", 32'(r), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule